// File: doc/BRIEF.md
# Prescaled Event Spy Tap

The tap sits on an event stream that moves one data word per handshake, with a flag on the final word of each event. It passes that stream straight through and, for the events it selects, also writes every word into a side spy data buffer. Once a selected event ends, it writes the event's word count into a companion spy length buffer. Monitoring software can then read whole events from the side buffers without touching the main data path.

A two-bit mode input picks the policy: copy nothing, copy every event, or copy one event in every n. n comes from a 16-bit prescale input, and a value of 0 there means 65536. The tap decides once per event, on its first word, and keeps that decision until the last word. If the spy buffer reports almost-full when an event starts, the tap skips that event and the main stream keeps moving. A debug control bit changes this: with it set, the main stream is held back until the spy buffer has room.

Top module: `spy_tap`

## Requirements
- R1: The main path is passed through with no delay. out_valid, out_data and out_last follow the inputs, and in_ready equals out_ready. A word moves on a cycle where in_valid and in_ready are both high. Nothing is copied on a cycle without such a transfer.
- R2: With mode code 0 (and also with the unused code 3), no event is copied. spy_data_we and spy_len_we stay low.
- R3: With mode code 1, every event is copied word for word. spy_data equals the transferred word in the same cycle that it is transferred.
- R4: With mode code 2 and prescale n, the first event that starts after the mode is entered is copied. After it, every n-th event is copied. With n = 1, every event is copied.
- R5: A prescale value of 0 behaves as n = 65536. After one copied event, the following events are not copied.
- R6: The copy decision is made on the first word of an event and held through its last word. A mode change in the middle of an event affects only later events.
- R7: One cycle after the last word of a copied event is transferred, spy_len_we pulses for a single cycle. spy_len then holds the number of words in that event.
- R8: When stall_en is 0 and spy_afull is high on an event's first word, the event is not copied. The one-in-n counter still advances for that event.
- R9: spy_afull rising in the middle of an event that is being copied does not cut the copy short.
- R10: When stall_en is 0, spy_afull never lowers in_ready or out_valid.
- R11: When stall_en is 1, spy_afull holds off any word that would be copied. in_ready and out_valid stay low, and there is no spy write. Once spy_afull falls, the word is transferred and copied.
- R12: After reset, no spy write is pending. The next word is treated as the first word of an event, and the one-in-n counter starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Copy policy: 0 none, 1 all, 2 one in n, 3 none |
| prescale | input | 16 | One-in-n divisor, 0 means 65536 |
| stall_en | input | 1 | Let spy almost-full hold the main stream |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Tap accepts upstream word |
| in_data | input | 32 | Upstream word |
| in_last | input | 1 | Upstream word is last of its event |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | 32 | Downstream word |
| out_last | output | 1 | Downstream word is last of its event |
| spy_data_we | output | 1 | Write strobe to spy data buffer |
| spy_data | output | 32 | Word written to spy data buffer |
| spy_len_we | output | 1 | Write strobe to spy length buffer |
| spy_len | output | 16 | Word count of the copied event |
| spy_afull | input | 1 | Spy buffer almost full |

## Verification
Single-word and multi-word events in copy-all mode show whether the length entry counts the last word and arrives one cycle late. Long runs of events under one-in-three, one-in-one and 65536 prescaling show whether the counter picks the right events, and whether a prescale value of 0 is mistaken for 1. Asserting almost-full on the first word, and separately in the middle of an event, shows the difference between a skip at the event boundary and a truncated copy, and the event after a skip confirms that the counter still moved. A mode change in mid-event, a stalled downstream and the debug stall bit each test that the decision is held and that copying is tied to real transfers.

// File: rtl/spy_tap_pkg.sv
package spy_tap_pkg;
  typedef enum logic [1:0] {
    SPY_OFF   = 2'd0,
    SPY_ALL   = 2'd1,
    SPY_PRESC = 2'd2,
    SPY_RSVD  = 2'd3
  } spy_mode_e;
endpackage

// File: rtl/spy_prescaler.sv
module spy_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] prescale,
  input  logic             advance,
  output logic             hit
);
  localparam int LIM_W = CNT_W + 1;

  // zero in the prescale field stands for the full 2**CNT_W range
  function automatic logic [LIM_W-1:0] limit_of(input logic [CNT_W-1:0] p);
    if (p == '0) limit_of = {1'b1, {CNT_W{1'b0}}};
    else         limit_of = {1'b0, p};
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] p);
    logic [LIM_W-1:0] nxt;
    nxt = {1'b0, c} + LIM_W'(1);
    if (nxt >= limit_of(p)) step = '0;
    else                    step = nxt[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) cnt_q <= '0;
    else if (advance)      cnt_q <= step(cnt_q, prescale);
  end

  assign hit = (cnt_q == '0);

  AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !advance) |=> (!$past(enable) || $stable(cnt_q) || !enable)); // R4
  AST_CNT_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hit || enable)); // R4
endmodule

// File: rtl/spy_len_ctr.sv
module spy_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word,
  input  logic             last,
  output logic             len_we,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] cnt_q;

  function automatic logic [LEN_W-1:0] bump(input logic [LEN_W-1:0] c);
    bump = c + LEN_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_we <= 1'b0;
      len    <= '0;
    end else begin
      len_we <= word && last;
      if (word) begin
        if (last) begin
          len   <= bump(cnt_q);
          cnt_q <= '0;
        end else begin
          cnt_q <= bump(cnt_q);
        end
      end
    end
  end

  AST_LEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    len_we |=> !len_we || $past(word && last)); // R7
endmodule

// File: rtl/spy_tap.sv
module spy_tap
  import spy_tap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  prescale,
  input  logic              stall_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              spy_data_we,
  output logic [DATA_W-1:0] spy_data,
  output logic              spy_len_we,
  output logic [LEN_W-1:0]  spy_len,
  input  logic              spy_afull
);
  spy_mode_e mode_e;
  logic at_bnd_q, cap_q;
  logic hit, want, cap_now, hold, xfer, ev_start, presc_on;

  assign mode_e   = spy_mode_e'(mode);
  assign presc_on = (mode_e == SPY_PRESC);
  assign want     = (mode_e == SPY_ALL) || (presc_on && hit);

  // decision: taken on first word, held afterwards
  assign cap_now = at_bnd_q ? (want && (stall_en || !spy_afull)) : cap_q;
  assign hold    = stall_en && spy_afull && in_valid && (at_bnd_q ? want : cap_q);

  assign out_valid = in_valid && !hold;
  assign in_ready  = out_ready && !hold;
  assign out_data  = in_data;
  assign out_last  = in_last;
  assign xfer      = in_valid && in_ready;
  assign ev_start  = xfer && at_bnd_q;

  assign spy_data_we = xfer && cap_now;
  assign spy_data    = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      at_bnd_q <= 1'b1;
      cap_q    <= 1'b0;
    end else if (xfer) begin
      at_bnd_q <= in_last;
      cap_q    <= in_last ? 1'b0 : cap_now;
    end
  end

  spy_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (presc_on),
    .prescale (prescale),
    .advance  (ev_start),
    .hit      (hit)
  );

  spy_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .word   (spy_data_we),
    .last   (in_last),
    .len_we (spy_len_we),
    .len    (spy_len)
  );

  AST_OFF_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !want) |-> !spy_data_we); // R2
  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !in_last) |=> (cap_q == $past(cap_now))); // R6
  AST_LEN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    spy_len_we |-> $past(spy_data_we && in_last)); // R7
  AST_NO_STALL_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_en && spy_afull) |-> (in_ready == out_ready && out_valid == in_valid)); // R10
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && spy_afull) |-> !spy_data_we); // R11
endmodule

// File: tb/spy_tap_test.sv
module spy_tap_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  mode = 0;
  logic [15:0] prescale = 16'd1;
  logic        stall_en = 0;
  logic        in_valid = 0;
  logic [31:0] in_data = 0;
  logic        in_last = 0;
  logic        out_ready = 1;
  logic        spy_afull = 0;
  logic        in_ready, out_valid, out_last, spy_data_we, spy_len_we;
  logic [31:0] out_data, spy_data;
  logic [15:0] spy_len;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] base = 32'h1000;

  always #2.5 clk = ~clk;

  spy_tap uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .prescale(prescale), .stall_en(stall_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .spy_data_we(spy_data_we), .spy_data(spy_data), .spy_len_we(spy_len_we),
    .spy_len(spy_len), .spy_afull(spy_afull)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    @(posedge clk);
  endtask

  // one event of n words; afull on the first word and on the later words
  task automatic send_event(input int n, input bit af_first, input bit af_rest,
                            input bit exp_cap, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1;
      in_data   = base + i;
      in_last   = (i == n - 1);
      spy_afull = (i == 0) ? af_first : af_rest;
      #1;
      if (i == 0 || i == n - 1) begin
        chk(out_valid && in_ready && out_data == in_data && out_last == in_last,
            "R1", out_data, in_data);
      end
      chk(spy_data_we == exp_cap, req, spy_data_we, exp_cap);
      if (exp_cap) chk(spy_data == base + i, "R3", spy_data, base + i);
      if (spy_afull && !stall_en) chk(in_ready == 1, "R10", in_ready, 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; spy_afull = 0;
    chk(spy_len_we == exp_cap, "R7", spy_len_we, exp_cap);
    if (exp_cap) chk(spy_len == n, "R7", spy_len, n);
    @(posedge clk);
    #1;
    chk(spy_len_we == 0, "R7", spy_len_we, 0);
    base = base + 32'h100;
  endtask

  task automatic t_reset();
    #1;
    chk(spy_data_we == 0 && spy_len_we == 0, "R12", spy_data_we, 0);
  endtask

  task automatic t_off();
    set_mode(2'd0);
    send_event(3, 0, 0, 0, "R2");
    send_event(1, 0, 0, 0, "R2");
    set_mode(2'd3);
    send_event(2, 0, 0, 0, "R2");
  endtask

  task automatic t_all();
    set_mode(2'd1);
    send_event(1, 0, 0, 1, "R3");
    send_event(4, 0, 0, 1, "R3");
  endtask

  task automatic t_one_in_three();
    set_mode(2'd0);
    prescale = 16'd3;
    set_mode(2'd2);
    for (int e = 0; e < 7; e++) send_event(2, 0, 0, (e % 3) == 0, "R4");
  endtask

  task automatic t_presc_one();
    set_mode(2'd0);
    prescale = 16'd1;
    set_mode(2'd2);
    for (int e = 0; e < 3; e++) send_event(1, 0, 0, 1, "R4");
  endtask

  task automatic t_presc_zero();
    set_mode(2'd0);
    prescale = 16'd0;
    set_mode(2'd2);
    send_event(1, 0, 0, 1, "R5");
    for (int e = 0; e < 4; e++) send_event(1, 0, 0, 0, "R5");
  endtask

  task automatic t_skip();
    set_mode(2'd0);
    prescale = 16'd2;
    set_mode(2'd2);
    send_event(2, 1, 0, 0, "R8");  // skipped, counter moves
    send_event(2, 0, 0, 0, "R8");
    send_event(2, 0, 0, 1, "R8");
  endtask

  task automatic t_mid_afull();
    set_mode(2'd1);
    send_event(5, 0, 1, 1, "R9");
  endtask

  task automatic t_mode_change();
    set_mode(2'd1);
    @(negedge clk);
    in_valid = 1; in_data = base; in_last = 0;
    #1 chk(spy_data_we == 1, "R6", spy_data_we, 1);
    @(posedge clk);
    @(negedge clk);
    mode = 2'd0; in_data = base + 1; in_last = 1;
    #1 chk(spy_data_we == 1, "R6", spy_data_we, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk(spy_len_we == 1 && spy_len == 2, "R6", spy_len, 2);
    base = base + 32'h100;
    send_event(1, 0, 0, 0, "R6");
  endtask

  task automatic t_stall();
    set_mode(2'd1);
    stall_en = 1;
    @(negedge clk);
    in_valid = 1; in_data = base; in_last = 1; spy_afull = 1;
    #1;
    chk(in_ready == 0 && out_valid == 0, "R11", in_ready, 0);
    chk(spy_data_we == 0, "R11", spy_data_we, 0);
    @(posedge clk);
    @(negedge clk);
    chk(in_ready == 0 && spy_data_we == 0, "R11", in_ready, 0);
    spy_afull = 0;
    #1;
    chk(in_ready == 1 && spy_data_we == 1 && spy_data == base, "R11", spy_data, base);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk(spy_len_we == 1 && spy_len == 1, "R11", spy_len, 1);
    stall_en = 0;
    base = base + 32'h100;
  endtask

  task automatic t_downstream_busy();
    set_mode(2'd1);
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_data = base; in_last = 1;
    #1;
    chk(in_ready == 0 && spy_data_we == 0, "R1", spy_data_we, 0);
    @(posedge clk);
    @(negedge clk);
    out_ready = 1;
    #1 chk(spy_data_we == 1, "R1", spy_data_we, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk(spy_len_we == 1 && spy_len == 1, "R7", spy_len, 1);
    base = base + 32'h100;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_off();
    t_all();
    t_one_in_three();
    t_presc_one();
    t_presc_zero();
    t_skip();
    t_mid_afull();
    t_mode_change();
    t_stall();
    t_downstream_busy();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule